// File: doc/BRIEF.md
# Four-Bank Row Cache Hit/Miss Controller

This block is the control logic of a DRAM that keeps one cached row page for each of its four internal banks. The row-enable strobe and the other command pins are sampled on a system clock. A high-to-low change of row enable opens a memory cycle. At that moment the block decodes the command from the chip-select, write/read and refresh pins. It selects a bank from the two row-bank bits and compares the row address with that bank's last-read tag. It then drives single-cycle strobes: load a row into the cache page, write the DRAM, write the cache page, and refresh a row.

The array, the cache storage and the analog timing are outside the block. They appear only as strobes with the bank and row that go with them. Every decoded cycle also produces a status code, so a controller or a bench can see how the cycle was classified. A window monitor counts internal refresh starts and raises a pulse when a window closes with too few of them. Every pin is a plain level or a one-cycle strobe. No data path passes through the block, so no port uses a valid/ready handshake and no port applies back-pressure.

Top module: `rcc_row_cache_ctl`

## Requirements
- R1: After reset, every bank tag is invalid, so the first read to any bank is a miss. All strobes, status_vld and rfsh_short are low, and the refresh counter is zero.
- R2: A row-enable fall with chip_sel_n low, wr_rd low and refresh_n high is a read. If the bank tag is valid and equal to row_addr, status is HIT (code 0) and row_load stays low.
- R3: A read whose row does not match the tag reports MISS (code 1). It pulses row_load with acc_bank/acc_row equal to the addressed bank and row, and the tag of that bank takes the new row.
- R4: In a write cycle (wr_rd high, refresh_n high, chip_sel_n low), status is HIT when the row matches the tag. Each write event then pulses dram_wr and cache_wr together.
- R5: A write cycle whose row does not match the tag reports MISS (code 1). Its write events pulse dram_wr only. The tag is not changed, so a later read of the old row still hits.
- R6: A write event occurs once each time col_latch_n and wr_en_n become low together while a write cycle is open. The event is suppressed when col_bank differs from the row bank of the cycle.
- R7: A write cycle in which col_latch_n never goes low is a row-only refresh. When row enable rises, rfsh pulses with rfsh_row = {row_bank, row_addr}. No write strobe is issued and no tag changes.
- R8: A row-enable fall with refresh_n low is an internal refresh, whatever the level of chip_sel_n. Status is REFRESH (code 2) and rfsh pulses with rfsh_row equal to the refresh counter. The counter increments, wrapping, when row enable rises.
- R9: A row-enable fall with chip_sel_n high and refresh_n high is illegal. Status is ILLEGAL (code 3), no strobe follows, and no tag or counter changes.
- R10: Every REF_WINDOW clock edges after reset, rfsh_short pulses if fewer than REF_MIN internal refresh starts were sampled in that window. A start sampled on the window's last edge counts toward that window.
- R11: status_vld, row_load and the refresh strobe of R8 are high for exactly the one cycle after the edge that samples the row-enable fall. dram_wr and cache_wr are high for one cycle after the edge that samples the write event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_en_n | input | 1 | Row enable, active low; a fall opens a cycle |
| chip_sel_n | input | 1 | Chip select, active low |
| wr_rd | input | 1 | 1 = write cycle, 0 = read cycle |
| refresh_n | input | 1 | Low at the fall requests an internal refresh |
| row_bank | input | BANK_W | Bank select carried in the row address |
| row_addr | input | ROW_W | Row address compared with the bank tag |
| col_bank | input | BANK_W | Bank select carried in the column address |
| col_latch_n | input | 1 | Column latch strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| status_vld | output | 1 | One-cycle pulse: a cycle was decoded |
| status | output | 2 | 0 HIT, 1 MISS, 2 REFRESH, 3 ILLEGAL |
| row_load | output | 1 | Load the addressed row into the bank's cache page |
| dram_wr | output | 1 | Write strobe to the DRAM array |
| cache_wr | output | 1 | Coherent write strobe to the cache page |
| acc_bank | output | BANK_W | Bank of the current read or write cycle |
| acc_row | output | ROW_W | Row of the current read or write cycle |
| rfsh | output | 1 | Refresh strobe (internal or row-only) |
| rfsh_row | output | BANK_W+ROW_W | Row refreshed by rfsh |
| rfsh_short | output | 1 | Window closed with too few internal refreshes |

## Verification
The refresh-window monitor and the command decoder can act on the same edge. This happens when an internal refresh fall is sampled exactly on the last edge of a window. The bench counts edges from reset release and places refresh falls at known edges. One window receives a single refresh, the next receives one refresh mid-window and one on its final edge, and the third receives none. It then requires exactly two deficit pulses, on the first and third window boundaries. A missing pulse, or an extra pulse at the shared edge, shows that the start was lost or counted in the wrong window.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [1:0] {
    ST_HIT     = 2'd0,
    ST_MISS    = 2'd1,
    ST_REFRESH = 2'd2,
    ST_ILLEGAL = 2'd3
  } cyc_status_e;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_READ    = 3'd1,
    CMD_WRITE   = 3'd2,
    CMD_REFRESH = 3'd3,
    CMD_ILLEGAL = 3'd4
  } cyc_cmd_e;

endpackage

// File: rtl/rcc_tag_store.sv
module rcc_tag_store #(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_hit,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row
);

  logic [ROW_W-1:0] tag_q [NBANK];
  logic [NBANK-1:0] vld_q;
  logic [NBANK-1:0] hit_vec;

  // one comparator per bank; the row bank bits pick the result
  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    assign hit_vec[b] = vld_q[b] && (tag_q[b] == lk_row);
  end

  assign lk_hit = hit_vec[lk_bank];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int b = 0; b < NBANK; b++) tag_q[b] <= '0;
    end else if (upd_en) begin
      for (int b = 0; b < NBANK; b++) begin
        if (upd_bank == BANK_W'(b)) begin
          tag_q[b] <= upd_row;
          vld_q[b] <= 1'b1;
        end
      end
    end
  end

  // R3: a read miss leaves the loaded row as a valid tag of that bank
  p_tag_loaded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (vld_q[$past(upd_bank)] && tag_q[$past(upd_bank)] == $past(upd_row)));

endmodule

// File: rtl/rcc_refresh_unit.sv
module rcc_refresh_unit #(
  parameter int RFSH_W     = 11,
  parameter int REF_WINDOW = 12_800_000,
  parameter int REF_MIN    = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done,
  output logic [RFSH_W-1:0] cnt,
  output logic              short_pulse
);

  localparam int WIN_W = (REF_WINDOW > 1) ? $clog2(REF_WINDOW) : 1;
  localparam int NUM_W = $clog2(REF_MIN + 1);
  localparam logic [WIN_W-1:0] LAST_EDGE = WIN_W'(REF_WINDOW - 1);
  localparam logic [NUM_W-1:0] MIN_V     = NUM_W'(REF_MIN);

  logic [RFSH_W-1:0] cnt_q;
  logic [WIN_W-1:0]  win_q;
  logic [NUM_W-1:0]  num_q, num_nx;
  logic              short_q;

  // saturating count of starts, including one sampled this edge
  assign num_nx = (num_q == MIN_V) ? num_q : num_q + NUM_W'(start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (done) begin
      cnt_q <= cnt_q + RFSH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      num_q   <= '0;
      short_q <= 1'b0;
    end else if (win_q == LAST_EDGE) begin
      win_q   <= '0;
      num_q   <= '0;
      short_q <= (num_nx < MIN_V);
    end else begin
      win_q   <= win_q + WIN_W'(1);
      num_q   <= num_nx;
      short_q <= 1'b0;
    end
  end

  assign cnt         = cnt_q;
  assign short_pulse = short_q;

  // R8: the address counter moves only at the end of an internal refresh
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(cnt_q));

  // R10: a deficit pulse only appears right after a window boundary
  p_short_at_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    short_q |-> (win_q == '0));

endmodule

// File: rtl/rcc_cycle_ctl.sv
module rcc_cycle_ctl
  import rcc_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 9,
  parameter int RFSH_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_en_n,
  input  logic              chip_sel_n,
  input  logic              wr_rd,
  input  logic              refresh_n,
  input  logic [BANK_W-1:0] row_bank,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [BANK_W-1:0] col_bank,
  input  logic              col_latch_n,
  input  logic              wr_en_n,
  input  logic              lk_hit,
  input  logic [RFSH_W-1:0] rf_cnt,
  output logic              upd_en,
  output logic              rf_start,
  output logic              rf_done,
  output logic              status_vld,
  output logic [1:0]        status,
  output logic              row_load,
  output logic              dram_wr,
  output logic              cache_wr,
  output logic [BANK_W-1:0] acc_bank,
  output logic [ROW_W-1:0]  acc_row,
  output logic              rfsh,
  output logic [RFSH_W-1:0] rfsh_row
);

  logic              ren_q;
  logic              fall, rise;
  cyc_cmd_e          cmd, kind_q;
  cyc_status_e       st_nx;
  logic              hit_q, col_seen_q, wc_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic              wr_cond, wr_evt, bank_ok, row_only;

  logic              status_vld_q, row_load_q, dram_wr_q, cache_wr_q, rfsh_q;
  cyc_status_e       status_q;
  logic [BANK_W-1:0] acc_bank_q;
  logic [ROW_W-1:0]  acc_row_q;
  logic [RFSH_W-1:0] rfsh_row_q;

  assign fall = ren_q & ~row_en_n;
  assign rise = ~ren_q & row_en_n;

  // command decode at the row-enable fall; refresh outranks chip select
  always_comb begin
    cmd = CMD_IDLE;
    if (fall) begin
      if (!refresh_n)     cmd = CMD_REFRESH;
      else if (chip_sel_n) cmd = CMD_ILLEGAL;
      else if (wr_rd)      cmd = CMD_WRITE;
      else                 cmd = CMD_READ;
    end
  end

  always_comb begin
    unique case (cmd)
      CMD_READ, CMD_WRITE: st_nx = lk_hit ? ST_HIT : ST_MISS;
      CMD_REFRESH:         st_nx = ST_REFRESH;
      default:             st_nx = ST_ILLEGAL;
    endcase
  end

  assign upd_en   = (cmd == CMD_READ) && !lk_hit;
  assign rf_start = (cmd == CMD_REFRESH);
  assign rf_done  = rise && (kind_q == CMD_REFRESH);
  assign row_only = rise && (kind_q == CMD_WRITE) && !col_seen_q;

  // a write event is the first cycle both column latch and write enable are low
  assign wr_cond = (kind_q == CMD_WRITE) && !row_en_n && !col_latch_n && !wr_en_n;
  assign wr_evt  = wr_cond && !wc_q;
  assign bank_ok = (col_bank == bank_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q      <= 1'b1;
      kind_q     <= CMD_IDLE;
      hit_q      <= 1'b0;
      bank_q     <= '0;
      row_q      <= '0;
      col_seen_q <= 1'b0;
      wc_q       <= 1'b0;
    end else begin
      ren_q <= row_en_n;
      wc_q  <= wr_cond;
      if (fall) begin
        kind_q     <= cmd;
        hit_q      <= lk_hit;
        bank_q     <= row_bank;
        row_q      <= row_addr;
        col_seen_q <= 1'b0;
      end else if (rise) begin
        kind_q     <= CMD_IDLE;
        col_seen_q <= 1'b0;
      end else if (kind_q == CMD_WRITE && !col_latch_n) begin
        col_seen_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_vld_q <= 1'b0;
      status_q     <= ST_HIT;
      row_load_q   <= 1'b0;
      dram_wr_q    <= 1'b0;
      cache_wr_q   <= 1'b0;
      acc_bank_q   <= '0;
      acc_row_q    <= '0;
      rfsh_q       <= 1'b0;
      rfsh_row_q   <= '0;
    end else begin
      status_vld_q <= fall;
      if (fall) status_q <= st_nx;
      row_load_q <= upd_en;
      dram_wr_q  <= wr_evt && bank_ok;
      cache_wr_q <= wr_evt && bank_ok && hit_q;
      if (cmd == CMD_READ || cmd == CMD_WRITE) begin
        acc_bank_q <= row_bank;
        acc_row_q  <= row_addr;
      end
      rfsh_q <= rf_start || row_only;
      if (rf_start)      rfsh_row_q <= rf_cnt;
      else if (row_only) rfsh_row_q <= {bank_q, row_q};
    end
  end

  assign status_vld = status_vld_q;
  assign status     = status_q;
  assign row_load   = row_load_q;
  assign dram_wr    = dram_wr_q;
  assign cache_wr   = cache_wr_q;
  assign acc_bank   = acc_bank_q;
  assign acc_row    = acc_row_q;
  assign rfsh       = rfsh_q;
  assign rfsh_row   = rfsh_row_q;

  // R2: a reported hit never fetches a row
  p_hit_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld_q && status_q == ST_HIT) |-> !row_load_q);

  // R3: a row load only accompanies a reported miss
  p_load_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_load_q |-> (status_vld_q && status_q == ST_MISS));

  // R4: the cache page is never written without the DRAM
  p_cache_with_dram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cache_wr_q |-> dram_wr_q);

  // R6: a DRAM write needs both strobes low on the sampling edge
  p_write_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dram_wr_q |-> $past(!col_latch_n && !wr_en_n && !row_en_n));

  // R9: an illegal cycle launches nothing
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld_q && status_q == ST_ILLEGAL) |-> (!row_load_q && !rfsh_q));

  // R11: the decode pulse never lasts two cycles
  p_vld_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status_vld_q |=> !status_vld_q);

endmodule

// File: rtl/rcc_row_cache_ctl.sv
module rcc_row_cache_ctl #(
  parameter int NBANK      = 4,
  parameter int ROW_W      = 9,
  parameter int REF_WINDOW = 12_800_000,
  parameter int REF_MIN    = 1024,
  localparam int BANK_W    = $clog2(NBANK),
  localparam int RFSH_W    = BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_en_n,
  input  logic              chip_sel_n,
  input  logic              wr_rd,
  input  logic              refresh_n,
  input  logic [BANK_W-1:0] row_bank,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [BANK_W-1:0] col_bank,
  input  logic              col_latch_n,
  input  logic              wr_en_n,
  output logic              status_vld,
  output logic [1:0]        status,
  output logic              row_load,
  output logic              dram_wr,
  output logic              cache_wr,
  output logic [BANK_W-1:0] acc_bank,
  output logic [ROW_W-1:0]  acc_row,
  output logic              rfsh,
  output logic [RFSH_W-1:0] rfsh_row,
  output logic              rfsh_short
);

  logic              lk_hit, upd_en, rf_start, rf_done;
  logic [RFSH_W-1:0] rf_cnt;

  rcc_tag_store #(
    .NBANK (NBANK),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W)
  ) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_bank (row_bank),
    .lk_row  (row_addr),
    .lk_hit  (lk_hit),
    .upd_en  (upd_en),
    .upd_bank(row_bank),
    .upd_row (row_addr)
  );

  rcc_refresh_unit #(
    .RFSH_W    (RFSH_W),
    .REF_WINDOW(REF_WINDOW),
    .REF_MIN   (REF_MIN)
  ) u_rfsh (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rf_start),
    .done       (rf_done),
    .cnt        (rf_cnt),
    .short_pulse(rfsh_short)
  );

  rcc_cycle_ctl #(
    .BANK_W(BANK_W),
    .ROW_W (ROW_W),
    .RFSH_W(RFSH_W)
  ) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_en_n   (row_en_n),
    .chip_sel_n (chip_sel_n),
    .wr_rd      (wr_rd),
    .refresh_n  (refresh_n),
    .row_bank   (row_bank),
    .row_addr   (row_addr),
    .col_bank   (col_bank),
    .col_latch_n(col_latch_n),
    .wr_en_n    (wr_en_n),
    .lk_hit     (lk_hit),
    .rf_cnt     (rf_cnt),
    .upd_en     (upd_en),
    .rf_start   (rf_start),
    .rf_done    (rf_done),
    .status_vld (status_vld),
    .status     (status),
    .row_load   (row_load),
    .dram_wr    (dram_wr),
    .cache_wr   (cache_wr),
    .acc_bank   (acc_bank),
    .acc_row    (acc_row),
    .rfsh       (rfsh),
    .rfsh_row   (rfsh_row)
  );

endmodule

// File: tb/rcc_row_cache_ctl_bench.sv
`timescale 1ns/1ps
module rcc_row_cache_ctl_bench;

  localparam int WIN = 64;
  localparam int MINR = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_en_n = 1'b1, chip_sel_n = 1'b0, wr_rd = 1'b0, refresh_n = 1'b1;
  logic [1:0] row_bank = '0, col_bank = '0;
  logic [8:0] row_addr = '0;
  logic col_latch_n = 1'b1, wr_en_n = 1'b1;
  logic status_vld, row_load, dram_wr, cache_wr, rfsh, rfsh_short;
  logic [1:0] status, acc_bank;
  logic [8:0] acc_row;
  logic [10:0] rfsh_row;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int ec = 0, short_n = 0, short_at = -1;

  logic [8:0]  tag_m [4];
  logic [3:0]  vld_m;
  logic [10:0] cnt_m;

  always #2.5 clk = ~clk;

  rcc_row_cache_ctl #(.REF_WINDOW(WIN), .REF_MIN(MINR)) u_rcc_row_cache_ctl (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .chip_sel_n(chip_sel_n),
    .wr_rd(wr_rd), .refresh_n(refresh_n), .row_bank(row_bank), .row_addr(row_addr),
    .col_bank(col_bank), .col_latch_n(col_latch_n), .wr_en_n(wr_en_n),
    .status_vld(status_vld), .status(status), .row_load(row_load), .dram_wr(dram_wr),
    .cache_wr(cache_wr), .acc_bank(acc_bank), .acc_row(acc_row), .rfsh(rfsh),
    .rfsh_row(rfsh_row), .rfsh_short(rfsh_short));

  always @(posedge clk) if (!rst_n) ec <= 0; else ec <= ec + 1;

  always @(negedge clk) begin
    if (!rst_n) begin short_n <= 0; short_at <= -1; end
    else if (rfsh_short) begin short_n <= short_n + 1; short_at <= ec; end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_status(input bit rf_n, input bit cs_n, input bit hit);
    if (!rf_n) return 2;
    if (cs_n) return 3;
    return hit ? 0 : 1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; row_en_n = 1'b1; chip_sel_n = 1'b0; refresh_n = 1'b1;
    col_latch_n = 1'b1; wr_en_n = 1'b1; wr_rd = 1'b0;
    repeat (3) @(negedge clk);
    vld_m = '0; cnt_m = '0;
    for (int b = 0; b < 4; b++) tag_m[b] = '0;
    rst_n = 1'b1;
  endtask

  // one complete row-enable cycle; called and returns at a falling clock edge
  task automatic run_cycle(input bit cs_n, input bit wr, input bit rf_n,
                           input logic [1:0] bk, input logic [8:0] rw,
                           input bit do_col, input logic [1:0] cbk, input bit we_lo);
    bit hit = vld_m[bk] && (tag_m[bk] == rw);
    bit is_rf = !rf_n;
    bit is_ill = rf_n && cs_n;
    bit is_wr = rf_n && !cs_n && wr;
    bit is_rd = rf_n && !cs_n && !wr;
    bit wr_go;
    string tag_s = is_rf ? "R8" : is_ill ? "R9" : is_wr ? (hit ? "R4" : "R5") : (hit ? "R2" : "R3");
    chip_sel_n = cs_n; wr_rd = wr; refresh_n = rf_n; row_bank = bk; row_addr = rw;
    row_en_n = 1'b0;
    @(negedge clk);
    chk("R11", "status_vld", status_vld, 1);
    chk(tag_s, "status", status, exp_status(rf_n, cs_n, hit));
    chk(tag_s, "row_load", row_load, (is_rd && !hit) ? 1 : 0);
    chk(tag_s, "rfsh at fall", rfsh, is_rf ? 1 : 0);
    if (is_rf) chk("R8", "rfsh_row counter", rfsh_row, cnt_m);
    if (is_rd && !hit) begin
      chk("R3", "acc_bank", acc_bank, bk);
      chk("R3", "acc_row", acc_row, rw);
      tag_m[bk] = rw; vld_m[bk] = 1'b1;
    end
    chip_sel_n = 1'b0; refresh_n = 1'b1;
    if (is_wr) begin
      col_latch_n = !do_col; wr_en_n = !we_lo; col_bank = cbk;
      @(negedge clk);
      chk("R11", "status_vld drop", status_vld, 0);
      wr_go = do_col && we_lo && (cbk == bk);
      chk("R6", "dram_wr", dram_wr, wr_go ? 1 : 0);
      chk(hit ? "R4" : "R5", "cache_wr", cache_wr, (wr_go && hit) ? 1 : 0);
      col_latch_n = 1'b1; wr_en_n = 1'b1;
      @(negedge clk);
      chk("R11", "dram_wr one cycle", dram_wr, 0);
    end
    row_en_n = 1'b1;
    @(negedge clk);
    chk("R7", "rfsh at rise", rfsh, (is_wr && !do_col) ? 1 : 0);
    if (is_wr && !do_col) chk("R7", "row-only rfsh_row", rfsh_row, {bk, rw});
    if (!is_wr) chk("R11", "status_vld drop", status_vld, 0);
    if (is_rf) cnt_m = cnt_m + 11'd1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    @(negedge clk);
    chk("R1", "status_vld", status_vld, 0);
    chk("R1", "row_load", row_load, 0);
    chk("R1", "dram_wr", dram_wr, 0);
    chk("R1", "cache_wr", cache_wr, 0);
    chk("R1", "rfsh", rfsh, 0);
    chk("R1", "rfsh_short", rfsh_short, 0);

    // R1/R3: first read to every bank misses
    for (int b = 0; b < 4; b++) run_cycle(0, 0, 1, 2'(b), 9'd7, 0, 0, 0);
    run_cycle(0, 0, 1, 2'd0, 9'd7, 0, 0, 0);          // R2 hit
    run_cycle(0, 1, 1, 2'd0, 9'd7, 1, 2'd0, 1);       // R4 write hit
    run_cycle(0, 1, 1, 2'd0, 9'd9, 1, 2'd0, 1);       // R5 write miss
    run_cycle(0, 0, 1, 2'd0, 9'd7, 0, 0, 0);          // R5 tag unchanged -> hit
    run_cycle(0, 1, 1, 2'd1, 9'd7, 1, 2'd2, 1);       // R6 bank mismatch
    run_cycle(0, 1, 1, 2'd1, 9'd7, 1, 2'd1, 0);       // R6 write enable high
    run_cycle(0, 1, 1, 2'd2, 9'd3, 0, 2'd2, 1);       // R7 row-only refresh
    run_cycle(0, 0, 1, 2'd2, 9'd7, 0, 0, 0);          // R7 tag unchanged -> hit
    run_cycle(0, 0, 0, 2'd1, 9'd1, 0, 0, 0);          // R8 refresh, cs low
    run_cycle(1, 0, 0, 2'd1, 9'd1, 0, 0, 0);          // R8 refresh, cs high
    run_cycle(1, 1, 1, 2'd3, 9'd5, 0, 0, 0);          // R9 illegal
    run_cycle(0, 0, 1, 2'd3, 9'd7, 0, 0, 0);          // R9 nothing changed -> hit

    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(99);
      logic [1:0] bk = 2'($urandom_range(3));
      logic [8:0] rw = 9'($urandom_range(3));
      if (k < 40)      run_cycle(0, 0, 1, bk, rw, 0, 0, 0);
      else if (k < 78) run_cycle(0, 1, 1, bk, rw, $urandom_range(9) != 0,
                                 ($urandom_range(4) == 0) ? 2'($urandom_range(3)) : bk,
                                 $urandom_range(7) != 0);
      else if (k < 92) run_cycle($urandom_range(1) == 1, $urandom_range(1) == 1, 0, bk, rw, 0, 0, 0);
      else             run_cycle(1, $urandom_range(1) == 1, 1, bk, rw, 0, 0, 0);
    end

    // R10: refresh windows of WIN edges, one start placed on a window's last edge
    do_reset();
    run_cycle(0, 0, 0, 0, 0, 0, 0, 0);                // fall on edge 1
    while (ec < 66) @(negedge clk);
    chk("R10", "pulses after window 1", short_n, 1);
    chk("R10", "window 1 pulse edge", short_at, WIN);
    run_cycle(0, 0, 0, 0, 0, 0, 0, 0);
    while (ec < 2 * WIN - 1) @(negedge clk);
    run_cycle(0, 0, 0, 0, 0, 0, 0, 0);                // fall on edge 2*WIN
    while (ec < 2 * WIN + 4) @(negedge clk);
    chk("R10", "boundary start counted", short_n, 1);
    while (ec < 3 * WIN + 3) @(negedge clk);
    chk("R10", "pulses after window 3", short_n, 2);
    chk("R10", "window 3 pulse edge", short_at, 3 * WIN);
    chk("R8", "counter after reset", rfsh_row, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule